// File: doc/BRIEF.md
# FIFO Reset and Configuration Sequencer

This block sits beside the storage of a two-clock FIFO and turns the slow, asynchronous reset pins into clean, per-domain events. A master reset and a partial reset each clear the read and write pointers. A retransmit request only rewinds the read pointer. The partial reset and the retransmit share one active-low request pin, and a role pin selects between them. Each request is synchronized separately into the write clock domain and the read clock domain. A counter in each domain checks that the request stayed low long enough before any strobe is issued. A request that is too short is dropped and flagged on an error output.

While a master or partial reset is in progress, the block raises a flag-force level in each domain. The FIFO uses it to drive its status flags to their reset values: input-ready low, output-ready low, almost-empty low, almost-full high and the mailbox flags high. The block also gates the write-side ready signal, which stays low until two write-clock cycles after the reset has been seen to end.

At the end of a valid master reset the block commits a configuration. It holds the byte-order select and the flag-offset method taken when the master reset pin rose. It also holds the read timing mode, taken from the same dual-purpose pin at the first write-clock edge after that rise. A partial reset leaves all of these settings as they were.

Top module: `fifo_rst_seq`

## Requirements
- R1: A master or partial reset request that is low for at least MIN_LOW_EDGES (default 4) rising edges of a port clock produces exactly one single-cycle pointer-clear strobe in that domain (`wr_ptr_clr` or `rd_ptr_clr`). The strobe is high in the cycle after the second clock edge that follows the release of the pin.
- R2: A request that is low for fewer than MIN_LOW_EDGES edges produces no strobe. Instead, the error output of each domain that saw it (`err_wr`, `err_rd`) pulses in the cycle where the strobe would have been.
- R3: `flag_force_wr` and `flag_force_rd` go high as soon as a master or partial reset request goes low, without waiting for a clock edge. They stay high until the request has passed through the synchronizer. A retransmit request does not raise them.
- R4: `full_ir_en` is low whenever `flag_force_wr` is high. It rises exactly two write-clock edges after `flag_force_wr` falls.
- R5: On the rising edge of `mrst_n`, the level of `be_fwft` is taken as the byte order: 1 selects big-endian and drives `big_endian` high.
- R6: On the same rising edge of `mrst_n`, `fsel` is taken as the flag-offset method. It appears unchanged on `ofs_method`.
- R7: `be_fwft` is sampled again at the first `clk_wr` edge after `mrst_n` rises. A high level there selects standard mode (`fwft_mode`=0) and a low level selects first-word-fall-through (`fwft_mode`=1).
- R8: While `prt_sel`=0, a valid low pulse on `prt_n` acts as a partial reset. It clears both pointers and leaves `big_endian`, `ofs_method` and `fwft_mode` unchanged.
- R9: While `prt_sel`=1, a valid low pulse on `prt_n` acts as a retransmit. It produces only `rd_rewind`, and neither pointer-clear strobe. `full_ir_en` stays high throughout.
- R10: The settings of R5 to R7 change only on a valid master reset. A master reset pulse shorter than the minimum leaves all three outputs at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_wr | input | 1 | Write-port clock |
| clk_rd | input | 1 | Read-port clock |
| mrst_n | input | 1 | Master reset request, active low, asynchronous |
| prt_n | input | 1 | Shared partial-reset / retransmit request, active low, asynchronous |
| prt_sel | input | 1 | Role of `prt_n`: 0 partial reset, 1 retransmit |
| be_fwft | input | 1 | Dual-purpose pin: byte order at release, then timing mode |
| fsel | input | FSEL_W | Flag-offset method select |
| wr_ptr_clr | output | 1 | Write-pointer clear strobe (clk_wr) |
| rd_ptr_clr | output | 1 | Read-pointer clear strobe (clk_rd) |
| rd_rewind | output | 1 | Read-pointer rewind strobe (clk_rd) |
| flag_force_wr | output | 1 | Force write-side flags to reset values |
| flag_force_rd | output | 1 | Force read-side flags to reset values |
| full_ir_en | output | 1 | Gate for the full / input-ready flag |
| err_wr | output | 1 | Too-short request seen in the write domain |
| err_rd | output | 1 | Too-short request seen in the read domain |
| big_endian | output | 1 | Committed byte order |
| ofs_method | output | FSEL_W | Committed flag-offset method |
| fwft_mode | output | 1 | Committed timing mode, 1 = first-word-fall-through |

## Verification
A wrong edge count shows up in the first cycle of the release window. A pulse at the boundary either gains a clear strobe it should not have, or loses one to an error pulse. Both effects appear two edges after the pin rises. A mis-timed capture of the dual-purpose pin shows up one cycle later, when the committed byte order and timing mode come out swapped or stale. A wrong ready-delay counter moves the rise of `full_ir_en` by a whole write cycle. Sampling that output on both sides of the second edge exposes this.

// File: rtl/fifo_rst_seq_pkg.sv
`timescale 1ns/1ps
package fifo_rst_seq_pkg;

  // Role of the shared request pin, chosen by prt_sel.
  typedef enum logic {
    PRT_PARTIAL = 1'b0,
    PRT_RETX    = 1'b1
  } prt_role_e;

  // Source slots inside each clock domain.
  localparam int unsigned SRC_MASTER  = 0;
  localparam int unsigned SRC_PARTIAL = 1;
  localparam int unsigned SRC_RETX    = 2;
  localparam int unsigned WR_SRCS     = 2;
  localparam int unsigned RD_SRCS     = 3;

  // Sources that force the status flags to their reset values.
  localparam logic [RD_SRCS-1:0] RD_FORCE_MASK = 3'b011;

  // Delay, in write clocks, from the end of a reset to input-ready.
  localparam int unsigned READY_DELAY = 2;

  // Edge count seen by a filter when the raw pin was low for min_low edges:
  // the synchronizer adds one edge per stage after the release.
  function automatic int unsigned pass_count(input int unsigned min_low,
                                             input int unsigned stages);
    return min_low + stages;
  endfunction

  // Timing-mode meaning of the second sample of the dual-purpose pin.
  function automatic logic fwft_from_pin(input logic pin_level);
    return ~pin_level;
  endfunction

endpackage

// File: rtl/fifo_rst_seq_filter.sv
`timescale 1ns/1ps
module fifo_rst_seq_filter #(
  parameter int unsigned MIN_LOW_EDGES = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic req_n,
  output logic active,
  output logic rel_ok,
  output logic rel_short
);
  import fifo_rst_seq_pkg::*;

  localparam int unsigned PASS  = pass_count(MIN_LOW_EDGES, SYNC_STAGES);
  localparam int unsigned CNT_W = $clog2(PASS + 1);
  localparam logic [CNT_W-1:0] PASS_V = CNT_W'(PASS);

  logic [SYNC_STAGES-1:0] chain;
  logic                   sync_q;
  logic                   sync_d;
  logic [CNT_W-1:0]       low_cnt;
  logic                   release_ev;

  // Assert asynchronously, release through SYNC_STAGES flops.
  always_ff @(posedge clk or negedge req_n) begin
    if (!req_n) chain <= '0;
    else        chain <= {chain[SYNC_STAGES-2:0], 1'b1};
  end

  assign sync_q = chain[SYNC_STAGES-1];

  // Count edges while the synchronized request is low, saturating at PASS.
  always_ff @(posedge clk) begin
    sync_d <= sync_q;
    if (!sync_q) begin
      if (low_cnt != PASS_V) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign release_ev = sync_q & ~sync_d;
  assign active     = ~sync_q;
  assign rel_ok     = release_ev & (low_cnt == PASS_V);
  assign rel_short  = release_ev & (low_cnt != PASS_V);

endmodule

// File: rtl/fifo_rst_seq_ready.sv
`timescale 1ns/1ps
module fifo_rst_seq_ready #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic force_in,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);
  localparam logic [CNT_W-1:0] DELAY_V = CNT_W'(DELAY);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (force_in)            cnt <= '0;
    else if (cnt != DELAY_V) cnt <= cnt + 1'b1;
  end

  // Drops at once with the force level, rises DELAY edges after it ends.
  assign ready = (cnt == DELAY_V) & ~force_in;

endmodule

// File: rtl/fifo_rst_seq_cfg.sv
`timescale 1ns/1ps
module fifo_rst_seq_cfg #(
  parameter int unsigned FSEL_W = 3
) (
  input  logic              clk_wr,
  input  logic              mrst_n,
  input  logic              be_pin,
  input  logic [FSEL_W-1:0] fsel,
  input  logic              commit,
  output logic              big_endian,
  output logic [FSEL_W-1:0] ofs_method,
  output logic              fwft_mode
);
  import fifo_rst_seq_pkg::*;

  logic              be_sh;
  logic [FSEL_W-1:0] fsel_sh;
  logic              mode_sh;
  logic              armed;

  // First sample: the level present when master reset rises.
  always_ff @(posedge mrst_n) begin
    be_sh   <= be_pin;
    fsel_sh <= fsel;
  end

  // Armed while master reset is low; the first write edge after the
  // release is the last one that samples the pin as the timing mode.
  always_ff @(posedge clk_wr or negedge mrst_n) begin
    if (!mrst_n) armed <= 1'b1;
    else         armed <= 1'b0;
  end

  always_ff @(posedge clk_wr) begin
    if (armed) mode_sh <= be_pin;
  end

  // Settings become visible only after the release is confirmed valid.
  always_ff @(posedge clk_wr) begin
    if (commit) begin
      big_endian <= be_sh;
      ofs_method <= fsel_sh;
      fwft_mode  <= fwft_from_pin(mode_sh);
    end
  end

endmodule

// File: rtl/fifo_rst_seq.sv
`timescale 1ns/1ps
module fifo_rst_seq #(
  parameter int unsigned MIN_LOW_EDGES = 4,
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned FSEL_W        = 3
) (
  input  logic              clk_wr,
  input  logic              clk_rd,
  input  logic              mrst_n,
  input  logic              prt_n,
  input  logic              prt_sel,
  input  logic              be_fwft,
  input  logic [FSEL_W-1:0] fsel,
  output logic              wr_ptr_clr,
  output logic              rd_ptr_clr,
  output logic              rd_rewind,
  output logic              flag_force_wr,
  output logic              flag_force_rd,
  output logic              full_ir_en,
  output logic              err_wr,
  output logic              err_rd,
  output logic              big_endian,
  output logic [FSEL_W-1:0] ofs_method,
  output logic              fwft_mode
);
  import fifo_rst_seq_pkg::*;

  // Requests decoded from the shared pin; a master reset also holds them,
  // so their release lines up with the master release and is masked.
  logic is_retx;
  logic prst_req_n;
  logic rtx_req_n;

  assign is_retx    = (prt_role_e'(prt_sel) == PRT_RETX);
  assign prst_req_n = (prt_n | is_retx) & mrst_n;
  assign rtx_req_n  = (prt_n | ~is_retx) & mrst_n;

  logic [WR_SRCS-1:0] w_req_n, w_active, w_ok, w_short;
  logic [RD_SRCS-1:0] r_req_n, r_active, r_ok, r_short;

  assign w_req_n = {prst_req_n, mrst_n};
  assign r_req_n = {rtx_req_n, prst_req_n, mrst_n};

  generate
    for (genvar i = 0; i < WR_SRCS; i++) begin : g_wr_src
      fifo_rst_seq_filter #(
        .MIN_LOW_EDGES(MIN_LOW_EDGES),
        .SYNC_STAGES  (SYNC_STAGES)
      ) filt_i (
        .clk      (clk_wr),
        .req_n    (w_req_n[i]),
        .active   (w_active[i]),
        .rel_ok   (w_ok[i]),
        .rel_short(w_short[i])
      );
    end
    for (genvar j = 0; j < RD_SRCS; j++) begin : g_rd_src
      fifo_rst_seq_filter #(
        .MIN_LOW_EDGES(MIN_LOW_EDGES),
        .SYNC_STAGES  (SYNC_STAGES)
      ) filt_i (
        .clk      (clk_rd),
        .req_n    (r_req_n[j]),
        .active   (r_active[j]),
        .rel_ok   (r_ok[j]),
        .rel_short(r_short[j])
      );
    end
  endgenerate

  // Named events used by the outputs and by the bound checker.
  logic m_busy_wr;
  logic m_busy_rd;
  logic cfg_commit;

  assign m_busy_wr  = w_active[SRC_MASTER] | w_ok[SRC_MASTER] | w_short[SRC_MASTER];
  assign m_busy_rd  = r_active[SRC_MASTER] | r_ok[SRC_MASTER] | r_short[SRC_MASTER];
  assign cfg_commit = w_ok[SRC_MASTER];

  // Write domain
  assign wr_ptr_clr    = w_ok[SRC_MASTER] | (w_ok[SRC_PARTIAL] & ~m_busy_wr);
  assign err_wr        = w_short[SRC_MASTER] | (w_short[SRC_PARTIAL] & ~m_busy_wr);
  assign flag_force_wr = |w_active;

  // Read domain
  assign rd_ptr_clr    = r_ok[SRC_MASTER] | (r_ok[SRC_PARTIAL] & ~m_busy_rd);
  assign rd_rewind     = r_ok[SRC_RETX] & ~m_busy_rd;
  assign err_rd        = r_short[SRC_MASTER] |
                         ((r_short[SRC_PARTIAL] | r_short[SRC_RETX]) & ~m_busy_rd);
  assign flag_force_rd = |(r_active & RD_FORCE_MASK);

  fifo_rst_seq_ready #(
    .DELAY(READY_DELAY)
  ) ready_i (
    .clk     (clk_wr),
    .force_in(flag_force_wr),
    .ready   (full_ir_en)
  );

  fifo_rst_seq_cfg #(
    .FSEL_W(FSEL_W)
  ) cfg_i (
    .clk_wr    (clk_wr),
    .mrst_n    (mrst_n),
    .be_pin    (be_fwft),
    .fsel      (fsel),
    .commit    (cfg_commit),
    .big_endian(big_endian),
    .ofs_method(ofs_method),
    .fwft_mode (fwft_mode)
  );

endmodule

// File: rtl/fifo_rst_seq_chk.sv
`timescale 1ns/1ps
module fifo_rst_seq_chk #(
  parameter int unsigned FSEL_W = 3
) (
  input logic              clk_wr,
  input logic              clk_rd,
  input logic              mrst_n,
  input logic              wr_ptr_clr,
  input logic              rd_ptr_clr,
  input logic              rd_rewind,
  input logic              err_wr,
  input logic              err_rd,
  input logic              flag_force_wr,
  input logic              flag_force_rd,
  input logic              full_ir_en,
  input logic              cfg_commit,
  input logic              big_endian,
  input logic [FSEL_W-1:0] ofs_method,
  input logic              fwft_mode
);

  // R1: a clear strobe lasts one write cycle
  a_r1_clr_single_cycle: assert property (@(posedge clk_wr) disable iff (!mrst_n)
    wr_ptr_clr |=> !wr_ptr_clr);

  // R2: a short request never also clears the write pointer
  a_r2_short_no_clear: assert property (@(posedge clk_wr) disable iff (!mrst_n)
    $onehot0({wr_ptr_clr, err_wr}));

  // R4: input-ready stays low while flags are forced
  a_r4_ir_low_in_force: assert property (@(posedge clk_wr) disable iff (!mrst_n)
    flag_force_wr |-> !full_ir_en);

  // R4: input-ready rises exactly two write edges after the force ends
  a_r4_ir_delay: assert property (@(posedge clk_wr) disable iff (!mrst_n)
    $rose(full_ir_en) |-> ($past(flag_force_wr, 3) && !$past(flag_force_wr, 2)));

  // R9: read-side events are mutually exclusive
  a_r9_rd_events_excl: assert property (@(posedge clk_rd) disable iff (!mrst_n)
    $onehot0({rd_ptr_clr, rd_rewind, err_rd}));

  // R9: a rewind comes without a flag force
  a_r9_rewind_no_force: assert property (@(posedge clk_rd) disable iff (!mrst_n)
    rd_rewind |-> !flag_force_rd);

  // R10: settings only move on a confirmed master release
  a_r10_cfg_hold: assert property (@(posedge clk_wr) disable iff (!mrst_n)
    !cfg_commit |=> $stable({big_endian, ofs_method, fwft_mode}));

endmodule

bind fifo_rst_seq fifo_rst_seq_chk #(.FSEL_W(FSEL_W)) chk_i (
  .clk_wr       (clk_wr),
  .clk_rd       (clk_rd),
  .mrst_n       (mrst_n),
  .wr_ptr_clr   (wr_ptr_clr),
  .rd_ptr_clr   (rd_ptr_clr),
  .rd_rewind    (rd_rewind),
  .err_wr       (err_wr),
  .err_rd       (err_rd),
  .flag_force_wr(flag_force_wr),
  .flag_force_rd(flag_force_rd),
  .full_ir_en   (full_ir_en),
  .cfg_commit   (cfg_commit),
  .big_endian   (big_endian),
  .ofs_method   (ofs_method),
  .fwft_mode    (fwft_mode)
);

// File: tb/fifo_rst_seq_tb_top.sv
`timescale 1ns/1ps
module fifo_rst_seq_tb_top;

  localparam int FSEL_W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              mrst_n, prt_n, prt_sel, be_fwft;
  logic [FSEL_W-1:0] fsel;
  logic              wr_ptr_clr, rd_ptr_clr, rd_rewind;
  logic              flag_force_wr, flag_force_rd, full_ir_en;
  logic              err_wr, err_rd, big_endian, fwft_mode;
  logic [FSEL_W-1:0] ofs_method;

  fifo_rst_seq #(.FSEL_W(FSEL_W)) dut_i (
    .clk_wr(clk), .clk_rd(clk), .mrst_n(mrst_n), .prt_n(prt_n),
    .prt_sel(prt_sel), .be_fwft(be_fwft), .fsel(fsel),
    .wr_ptr_clr(wr_ptr_clr), .rd_ptr_clr(rd_ptr_clr), .rd_rewind(rd_rewind),
    .flag_force_wr(flag_force_wr), .flag_force_rd(flag_force_rd),
    .full_ir_en(full_ir_en), .err_wr(err_wr), .err_rd(err_rd),
    .big_endian(big_endian), .ofs_method(ofs_method), .fwft_mode(fwft_mode)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 master, 1 partial, 2 retransmit
  typedef struct packed {
    logic [1:0]        kind;
    logic [3:0]        nlow;
    logic              be;
    logic [FSEL_W-1:0] fs;
    logic              mode;
    logic              e_wclr;
    logic              e_rclr;
    logic              e_rew;
    logic              e_ewr;
    logic              e_erd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd4, 1'b1, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd7, 1'b0, 3'b010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd0, 4'd3, 1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd1, 4'd4, 1'b1, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 4'd2, 1'b1, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    '{2'd2, 4'd4, 1'b1, 3'b110, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{2'd2, 4'd3, 1'b0, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{2'd0, 4'd5, 1'b1, 3'b011, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{2'd1, 4'd9, 1'b0, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  // Reference settings, updated only by valid master resets.
  logic              m_be, m_fw;
  logic [FSEL_W-1:0] m_fs;

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mrst_n = 1'b0; prt_n = 1'b1; prt_sel = 1'b0; be_fwft = 1'b0; fsel = '0;

    // Reset state, R3 and R4
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 force_wr in reset", flag_force_wr, 1'b1);
    chk("R3 force_rd in reset", flag_force_rd, 1'b1);
    chk("R4 ir low in reset", full_ir_en, 1'b0);
    chk("R1 no clr in reset", wr_ptr_clr, 1'b0);

    // Power-up master reset: big-endian, method 001, standard mode
    be_fwft = 1'b1; fsel = 3'b001;
    repeat (4) @(posedge clk);
    #1 mrst_n = 1'b1;
    #1 be_fwft = 1'b1;
    m_be = 1'b1; m_fs = 3'b001; m_fw = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R5 power-up endian", big_endian, m_be);
    chk("R6 power-up method", ofs_method, m_fs);
    chk("R7 power-up mode standard", fwft_mode, m_fw);
    chk("R4 ir high after reset", full_ir_en, 1'b1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      bit   is_rtx;
      v = VECS[i];
      is_rtx = (v.kind == 2'd2);
      @(posedge clk);
      #1;
      prt_sel = is_rtx;
      be_fwft = v.be;
      fsel    = v.fs;
      if (v.kind == 2'd0) mrst_n = 1'b0;
      else                prt_n  = 1'b0;
      #1;
      chk($sformatf("R3 async force_wr vec%0d", i), flag_force_wr, !is_rtx);
      chk($sformatf("R3 async force_rd vec%0d", i), flag_force_rd, !is_rtx);
      chk($sformatf("R9 R4 ir during request vec%0d", i), full_ir_en, is_rtx);

      repeat (int'(v.nlow)) @(posedge clk);
      #1;
      if (v.kind == 2'd0) begin
        mrst_n = 1'b1;
        #1 be_fwft = v.mode;
      end else begin
        prt_n = 1'b1;
      end
      if (v.kind == 2'd0 && v.nlow >= 4) begin
        m_be = v.be; m_fs = v.fs; m_fw = !v.mode;
      end

      // Release window: second edge after the pin rose
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1 R8 wr_ptr_clr vec%0d", i), wr_ptr_clr, v.e_wclr);
      chk($sformatf("R1 R8 rd_ptr_clr vec%0d", i), rd_ptr_clr, v.e_rclr);
      chk($sformatf("R9 rd_rewind vec%0d", i), rd_rewind, v.e_rew);
      chk($sformatf("R2 err_wr vec%0d", i), err_wr, v.e_ewr);
      chk($sformatf("R2 err_rd vec%0d", i), err_rd, v.e_erd);
      chk($sformatf("R4 ir not yet vec%0d", i), full_ir_en, is_rtx);

      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R1 strobes single vec%0d", i),
          {29'd0, wr_ptr_clr, rd_ptr_clr, rd_rewind}, 32'd0);
      chk($sformatf("R5 R10 endian vec%0d", i), big_endian, m_be);
      chk($sformatf("R6 R8 method vec%0d", i), ofs_method, m_fs);
      chk($sformatf("R7 R10 mode vec%0d", i), fwft_mode, m_fw);
      chk($sformatf("R4 ir one edge vec%0d", i), full_ir_en, is_rtx);

      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R4 ir two edges vec%0d", i), full_ir_en, 1'b1);
      repeat (3) @(posedge clk);
    end

    // Directed: retransmit holds pointers and settings, input-ready stays up
    @(posedge clk);
    #1 prt_sel = 1'b1; prt_n = 1'b0; be_fwft = 1'b0; fsel = 3'b110;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R9 ir held in long retransmit", full_ir_en, 1'b1);
    chk("R9 no force in retransmit", flag_force_wr, 1'b0);
    #1 prt_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 long retransmit rewinds", rd_rewind, 1'b1);
    chk("R9 long retransmit no wr clr", wr_ptr_clr, 1'b0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 R10 settings kept", {big_endian, fwft_mode, ofs_method}, {m_be, m_fw, m_fs});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule